// File: doc/BRIEF.md
# Video-Mode Packet Header Scheduler

This block emits, one frame after another, the ordered stream of packet headers that a display serial link transmitter needs in video mode. Each header is a data identifier (a 2-bit virtual channel over a 6-bit data type) plus a 16-bit word count. Headers go out under ready/valid handshaking to a downstream packer, which adds the payload, ECC and CRC and hands the bytes to the lanes.

The frame shape comes from four vertical line counts (sync, back porch, active, front porch) and from horizontal byte counts for the sync, back-porch, active and front-porch regions. A few mode bits control the output. One bit sends sync-end events on blanking lines. Three bits drop the horizontal blanking regions one by one. One bit picks burst or non-burst filling of the active area. One bit folds the vertical sync and back-porch lines away. One bit suppresses the end-of-transmission packets. A 2-bit field sets the virtual channel. All of these settings are captured once per frame, in a single idle cycle before the first header of that frame.

Top module: `dsi_vid_sched`

## Requirements
- R1: While `rst_n` is low, `hdr_valid` is 0. The first cycle after reset is idle. The first header of every frame carries data type 0x01 (vertical sync start) with word count 0.
- R2: `hdr_di[7:6]` holds the captured virtual channel (0 to 3) and `hdr_di[5:0]` holds the data type.
- R3: Data type codes are fixed. Vertical sync start is 0x01, vertical sync end 0x11, horizontal sync start 0x21, horizontal sync end 0x31, blanking 0x19, null 0x09 and end of transmission 0x08. Sync and end-of-transmission headers have word count 0. A blanking header's word count is the byte count of its region.
- R4: Frame lines run in this order: sync lines, back-porch lines, active lines, front-porch lines. Every line opens with one sync-start header. It is 0x01 on line 0. It is 0x11 on the first line after the sync lines, when there is at least one sync line. Otherwise it is 0x21.
- R5: A line outside the active area carries its opening header, then 0x31 only when `cfg_hse_en` is 1, then the end-of-transmission header.
- R6: An active line carries these headers in order: opening header, sync blanking (`cfg_hsa` bytes), 0x31, back-porch blanking (`cfg_hbp` bytes), pixel header (type `cfg_pix_dt`, `cfg_hact` bytes), null filler, front-porch blanking (`cfg_hfp` bytes), end of transmission.
- R7: Setting `cfg_skip_hsa`, `cfg_skip_hbp` or `cfg_skip_hfp` removes only that region's blanking header from active lines.
- R8: With `cfg_burst` at 0, each active line carries a null header of `cfg_null_bytes` bytes right after the pixel header. With `cfg_burst` at 1, no null header is sent.
- R9: With `cfg_auto_vcnt` at 1, the sync and back-porch line counts are treated as zero. The frame then consists of the active lines followed by the front-porch lines, and no 0x11 header is sent.
- R10: With `cfg_eot_off` at 1, no end-of-transmission header is sent.
- R11: While `hdr_valid` is 1 and `hdr_ready` is 0, the header holds and stays valid.
- R12: Configuration inputs are captured only in the one idle cycle between frames, so changes made mid-frame apply from the next frame on. That idle cycle is the only cycle with `hdr_valid` at 0 outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_vsa | input | LINE_W | Vertical sync line count |
| cfg_vbp | input | LINE_W | Vertical back-porch line count |
| cfg_vact | input | LINE_W | Active line count (at least 1) |
| cfg_vfp | input | LINE_W | Vertical front-porch line count |
| cfg_hsa | input | WC_W | Horizontal sync region bytes |
| cfg_hbp | input | WC_W | Horizontal back-porch bytes |
| cfg_hact | input | WC_W | Active pixel bytes per line |
| cfg_hfp | input | WC_W | Horizontal front-porch bytes |
| cfg_null_bytes | input | WC_W | Null filler bytes per active line in non-burst mode |
| cfg_pix_dt | input | 6 | Data type of the pixel header |
| cfg_vc | input | 2 | Virtual channel |
| cfg_burst | input | 1 | Burst mode, no null filler |
| cfg_hse_en | input | 1 | Send sync-end headers on blanking lines |
| cfg_skip_hsa | input | 1 | Drop the horizontal sync blanking header |
| cfg_skip_hbp | input | 1 | Drop the horizontal back-porch blanking header |
| cfg_skip_hfp | input | 1 | Drop the horizontal front-porch blanking header |
| cfg_auto_vcnt | input | 1 | Skip the vertical sync and back-porch lines |
| cfg_eot_off | input | 1 | Suppress end-of-transmission headers |
| hdr_valid | output | 1 | Header valid |
| hdr_ready | input | 1 | Downstream accepts the header |
| hdr_di | output | 8 | Data identifier |
| hdr_wc | output | WC_W | Word count |

## Verification
The assertions take for granted that the active line count is at least 1 and that `hdr_ready` may stall at any time. They also assume that the configuration is free to change in any cycle, because only the idle frame-start cycle samples it. The stimulus keeps the active count non-zero and toggles ready pseudo-randomly, stalling about one cycle in four. It changes the configuration one nanosecond after a clock edge, partway through frames. The reference model builds each frame's expected header list from the configuration as it stands in the idle cycle, and compares every accepted header against that list.

// File: rtl/dsi_vid_sched.sv
module dsi_vid_sched #(
  parameter int LINE_W = 12,
  parameter int WC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] cfg_vsa,
  input  logic [LINE_W-1:0] cfg_vbp,
  input  logic [LINE_W-1:0] cfg_vact,
  input  logic [LINE_W-1:0] cfg_vfp,
  input  logic [WC_W-1:0]   cfg_hsa,
  input  logic [WC_W-1:0]   cfg_hbp,
  input  logic [WC_W-1:0]   cfg_hact,
  input  logic [WC_W-1:0]   cfg_hfp,
  input  logic [WC_W-1:0]   cfg_null_bytes,
  input  logic [5:0]        cfg_pix_dt,
  input  logic [1:0]        cfg_vc,
  input  logic              cfg_burst,
  input  logic              cfg_hse_en,
  input  logic              cfg_skip_hsa,
  input  logic              cfg_skip_hbp,
  input  logic              cfg_skip_hfp,
  input  logic              cfg_auto_vcnt,
  input  logic              cfg_eot_off,
  output logic              hdr_valid,
  input  logic              hdr_ready,
  output logic [7:0]        hdr_di,
  output logic [WC_W-1:0]   hdr_wc
);
  localparam int SUM_W = LINE_W + 2;

  typedef enum logic [3:0] {
    ST_LOAD, ST_SYNC, ST_HSA, ST_HSE, ST_HBP, ST_PIX, ST_NUL, ST_HFP, ST_EOT
  } step_t;

  step_t            step, nxt;
  logic [SUM_W-1:0] ln, r_evsa, r_act_lo, r_act_hi, r_last;
  logic [WC_W-1:0]  r_hsa, r_hbp, r_hact, r_hfp, r_null;
  logic [5:0]       r_pdt, dt;
  logic [1:0]       r_vc;
  logic             r_burst, r_hse, r_shsa, r_shbp, r_shfp, r_eotoff;
  logic [8:0]       en;
  logic             is_act, line_end, frame_end, fire;

  logic [SUM_W-1:0] in_evsa, in_evbp, in_lo, in_hi;
  assign in_evsa = cfg_auto_vcnt ? '0 : SUM_W'(cfg_vsa);
  assign in_evbp = cfg_auto_vcnt ? '0 : SUM_W'(cfg_vbp);
  assign in_lo   = in_evsa + in_evbp;
  assign in_hi   = in_lo + SUM_W'(cfg_vact);

  assign is_act = (ln >= r_act_lo) && (ln < r_act_hi);

  always_comb begin
    en = '0;
    en[ST_SYNC] = 1'b1;
    en[ST_EOT]  = !r_eotoff;
    if (is_act) begin
      en[ST_HSA] = !r_shsa;
      en[ST_HSE] = 1'b1;
      en[ST_HBP] = !r_shbp;
      en[ST_PIX] = 1'b1;
      en[ST_NUL] = !r_burst;
      en[ST_HFP] = !r_shfp;
    end else begin
      en[ST_HSE] = r_hse;
    end
  end

  always_comb begin
    nxt = ST_LOAD;
    for (int i = 8; i >= 1; i--)
      if (4'(i) > step && en[i]) nxt = step_t'(4'(i));
  end

  assign line_end  = (nxt == ST_LOAD);
  assign frame_end = line_end && (ln == r_last);
  assign hdr_valid = (step != ST_LOAD);
  assign fire      = hdr_valid && hdr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= ST_LOAD;
      ln       <= '0;
      r_evsa   <= '0;
      r_act_lo <= '0;
      r_act_hi <= '0;
      r_last   <= '0;
      r_hsa    <= '0;
      r_hbp    <= '0;
      r_hact   <= '0;
      r_hfp    <= '0;
      r_null   <= '0;
      r_pdt    <= '0;
      r_vc     <= '0;
      r_burst  <= 1'b0;
      r_hse    <= 1'b0;
      r_shsa   <= 1'b0;
      r_shbp   <= 1'b0;
      r_shfp   <= 1'b0;
      r_eotoff <= 1'b0;
    end else if (step == ST_LOAD) begin
      step     <= ST_SYNC;
      ln       <= '0;
      r_evsa   <= in_evsa;
      r_act_lo <= in_lo;
      r_act_hi <= in_hi;
      r_last   <= in_hi + SUM_W'(cfg_vfp) - SUM_W'(1);
      r_hsa    <= cfg_hsa;
      r_hbp    <= cfg_hbp;
      r_hact   <= cfg_hact;
      r_hfp    <= cfg_hfp;
      r_null   <= cfg_null_bytes;
      r_pdt    <= cfg_pix_dt;
      r_vc     <= cfg_vc;
      r_burst  <= cfg_burst;
      r_hse    <= cfg_hse_en;
      r_shsa   <= cfg_skip_hsa;
      r_shbp   <= cfg_skip_hbp;
      r_shfp   <= cfg_skip_hfp;
      r_eotoff <= cfg_eot_off;
    end else if (fire) begin
      if (!line_end) step <= nxt;
      else if (frame_end) step <= ST_LOAD;
      else begin
        step <= ST_SYNC;
        ln   <= ln + SUM_W'(1);
      end
    end
  end

  always_comb begin
    dt     = 6'h00;
    hdr_wc = '0;
    case (step)
      ST_SYNC: dt = (ln == '0) ? 6'h01 :
                    ((ln == r_evsa) && (r_evsa != '0)) ? 6'h11 : 6'h21;
      ST_HSA:  begin dt = 6'h19; hdr_wc = r_hsa;  end
      ST_HSE:  dt = 6'h31;
      ST_HBP:  begin dt = 6'h19; hdr_wc = r_hbp;  end
      ST_PIX:  begin dt = r_pdt; hdr_wc = r_hact; end
      ST_NUL:  begin dt = 6'h09; hdr_wc = r_null; end
      ST_HFP:  begin dt = 6'h19; hdr_wc = r_hfp;  end
      ST_EOT:  dt = 6'h08;
      default: dt = 6'h00;
    endcase
  end

  assign hdr_di = {r_vc, dt};
endmodule

module dsi_vid_sched_chk #(
  parameter int WC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hdr_valid,
  input logic            hdr_ready,
  input logic [7:0]      hdr_di,
  input logic [WC_W-1:0] hdr_wc
);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_di) && $stable(hdr_wc));

  p_short_wc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && (hdr_di[5:0] == 6'h01 || hdr_di[5:0] == 6'h11 || hdr_di[5:0] == 6'h21 ||
                  hdr_di[5:0] == 6'h31 || hdr_di[5:0] == 6'h08) |-> hdr_wc == '0);

  p_one_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> hdr_valid);

  p_frame_head_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> hdr_di[5:0] == 6'h01);

  p_vc_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_ready |=> !hdr_valid || hdr_di[7:6] == $past(hdr_di[7:6]));

  p_eot_ends_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_ready && hdr_di[5:0] == 6'h08 |=>
      !hdr_valid || hdr_di[5:0] == 6'h01 || hdr_di[5:0] == 6'h11 || hdr_di[5:0] == 6'h21);
endmodule

bind dsi_vid_sched dsi_vid_sched_chk #(.WC_W(WC_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
  .hdr_di(hdr_di), .hdr_wc(hdr_wc)
);

// File: tb/test_dsi_vid_sched.sv
module test_dsi_vid_sched;
  localparam int LINE_W = 12;
  localparam int WC_W   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LINE_W-1:0] vsa, vbp, vact, vfp;
  logic [WC_W-1:0]   hsa, hbp, hact, hfp, nulb;
  logic [5:0]        pdt;
  logic [1:0]        vc;
  logic burst, hse, shsa, shbp, shfp, autov, eotoff;
  logic hdr_valid, hdr_ready = 1'b0;
  logic [7:0] hdr_di;
  logic [WC_W-1:0] hdr_wc;

  always #2 clk = ~clk;

  dsi_vid_sched #(.LINE_W(LINE_W), .WC_W(WC_W)) i_dsi_vid_sched (
    .clk(clk), .rst_n(rst_n),
    .cfg_vsa(vsa), .cfg_vbp(vbp), .cfg_vact(vact), .cfg_vfp(vfp),
    .cfg_hsa(hsa), .cfg_hbp(hbp), .cfg_hact(hact), .cfg_hfp(hfp),
    .cfg_null_bytes(nulb), .cfg_pix_dt(pdt), .cfg_vc(vc),
    .cfg_burst(burst), .cfg_hse_en(hse), .cfg_skip_hsa(shsa),
    .cfg_skip_hbp(shbp), .cfg_skip_hfp(shfp), .cfg_auto_vcnt(autov),
    .cfg_eot_off(eotoff),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_di(hdr_di), .hdr_wc(hdr_wc)
  );

  int total = 0, bad = 0, frames = 0, cycles = 0;
  logic [23:0] q[$];
  string tag = "R4", frame_tag = "R4";
  logic pv = 1'b0, pr = 1'b0;
  logic [7:0] pdi = '0;
  logic [WC_W-1:0] pwc = '0;

  function automatic void push(logic [5:0] t, logic [WC_W-1:0] w);
    q.push_back({vc, t, w});
  endfunction

  function automatic void build();
    int ev_s, ev_b, lo, hi, tot;
    ev_s = autov ? 0 : int'(vsa);
    ev_b = autov ? 0 : int'(vbp);
    lo = ev_s + ev_b;
    hi = lo + int'(vact);
    tot = hi + int'(vfp);
    for (int l = 0; l < tot; l++) begin
      if (l == 0) push(6'h01, '0);
      else if (l == ev_s && ev_s != 0) push(6'h11, '0);
      else push(6'h21, '0);
      if (l >= lo && l < hi) begin
        if (!shsa) push(6'h19, hsa);
        push(6'h31, '0);
        if (!shbp) push(6'h19, hbp);
        push(pdt, hact);
        if (!burst) push(6'h09, nulb);
        if (!shfp) push(6'h19, hfp);
      end else if (hse) push(6'h31, '0);
      if (!eotoff) push(6'h08, '0);
    end
  endfunction

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [23:0] e;
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog R12: actual=%0d expected=<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (!rst_n) begin
      hdr_ready = 1'b0;
      chk(hdr_valid == 1'b0, "R1", {15'd0, hdr_valid}, 24'd0);
    end else begin
      if (pv && !pr)
        chk(hdr_valid && hdr_di == pdi && hdr_wc == pwc, "R11",
            {hdr_di, hdr_wc}, {pdi, pwc});
      if (q.size() == 0) begin
        chk(hdr_valid == 1'b0, "R12", {23'd0, hdr_valid}, 24'd0);
        build();
        frame_tag = tag;
        frames++;
      end else if (!hdr_valid) begin
        chk(1'b0, "R12", 24'd0, 24'd1);
      end
      hdr_ready = ($urandom_range(3) != 0);
      if (hdr_valid && hdr_ready && q.size() != 0) begin
        e = q.pop_front();
        chk({hdr_di, hdr_wc} == e, frame_tag, {hdr_di, hdr_wc}, e);
      end
      pv = hdr_valid; pr = hdr_ready; pdi = hdr_di; pwc = hdr_wc;
    end
  end

  task automatic next_cfg(input int after);
    wait (frames >= after);
    repeat (9) @(posedge clk);
    #1;
  endtask

  initial begin
    vsa = 2; vbp = 1; vact = 3; vfp = 2;
    hsa = 4; hbp = 6; hact = 40; hfp = 8; nulb = 5; pdt = 6'h3E; vc = 2'd1;
    burst = 0; hse = 0; shsa = 0; shbp = 0; shfp = 0; autov = 0; eotoff = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    next_cfg(2); tag = "R5"; hse = 1; vc = 2'd2;
    next_cfg(4); tag = "R7"; hse = 0; shsa = 1; shfp = 1; vc = 2'd0;
    next_cfg(6); tag = "R8"; shsa = 0; shfp = 0; shbp = 1; burst = 1; nulb = 11;
    next_cfg(8); tag = "R9"; shbp = 0; burst = 0; autov = 1; vsa = 3; vbp = 2; vact = 2;
    next_cfg(10); tag = "R10"; autov = 0; vsa = 0; vbp = 2; eotoff = 1; vc = 2'd3; hse = 1;
    next_cfg(12); tag = "R6"; vsa = 1; vbp = 0; vfp = 0; vact = 2; eotoff = 0; hse = 0;
    hsa = 16'hFFFF; hact = 16'd3; pdt = 6'h1E; vc = 2'd2;
    wait (frames >= 15);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule